// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit CPU

This block runs the entry into an interrupt handler for a small 8-bit processor with a downward-growing stack in one fixed page. It watches two request lines. The non-maskable request is caught on its rising edge. The maskable request is held in a latch, but only while the core's interrupt-disable flag is clear. When the core presents an instruction boundary, a pending request takes the place of the next opcode fetch. The block then runs the same five-step sequence the core uses for its software break opcode: it writes the return address high byte, then the return address low byte, then the status byte to the stack, and reads a two-byte vector.

Hardware and software entries differ in three ways. A hardware entry saves the current PC as it is, while a software break saves PC+2 to step over its padding byte. The saved break bit is 0 for a hardware entry and 1 for a software break. The non-maskable request uses its own vector. When the sequence finishes, the block gives the core three values for one cycle, marked by a done pulse: the new PC, the new stack pointer, and the new status with interrupt-disable set.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request is latched only on a clock edge where `irq_req` is high and `status_in` bit 2 (interrupt-disable) is 0. A request raised while that bit is 1 is lost. The non-maskable request is latched whatever bit 2 holds.
- R2: A pending request is taken only in a cycle with `boundary` high and `busy` low. In that cycle `take_int` is 1, and the first stack write follows on the next cycle.
- R3: The saved return address is `pc_in` for a hardware entry and `pc_in`+2 (modulo 2^16) for a software break.
- R4: Exactly three writes take place, one per cycle, to address 0x0100+SP, in this order: PC high byte, PC low byte, status. SP decrements modulo 256 after each write, and `sp_out` equals `sp_in`-3 modulo 256.
- R5: The saved status is `status_in` with bit 5 forced to 1 and bit 4 (break) set to 0 for a hardware entry or 1 for a software break.
- R6: `status_out` equals `status_in` with bit 2 set to 1. All other bits, including bit 3 (decimal), are unchanged.
- R7: The new PC is read little-endian, low byte first. It comes from 0xFFFA/0xFFFB for a non-maskable entry and from 0xFFFE/0xFFFF for a maskable entry or a break.
- R8: When both kinds are pending at one boundary, the non-maskable entry runs first. The maskable request stays pending and is taken at a later boundary.
- R9: A non-maskable request held high gives only one entry. A new entry needs a new rising edge.
- R10: Each entry clears its own pending latch once the vector is loaded, so one request gives one entry. `done` is a single-cycle pulse, 6 cycles after the boundary cycle.
- R11: When a request is pending and `brk_req` is high at the same boundary, the hardware entry runs. `boundary` and `brk_req` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| irq_req | input | 1 | Maskable request, level |
| boundary | input | 1 | Core is at an instruction boundary |
| brk_req | input | 1 | Opcode at the boundary is the software break |
| pc_in | input | 16 | Current PC (break opcode address for software break) |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status byte, bit 2 interrupt-disable |
| take_int | output | 1 | Opcode fetch is replaced by a hardware entry |
| busy | output | 1 | Sequence in progress |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data expected in the same cycle |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Entry complete; outputs below valid |
| pc_out | output | 16 | New PC from the vector |
| sp_out | output | 8 | New stack pointer |
| status_out | output | 8 | New status byte |

## Verification
Two things can happen in the same cycle: starting a hardware entry and starting a software break. They coincide when a boundary arrives with `brk_req` high while a latched maskable request is waiting. The bench builds this case by latching a request one cycle before the break boundary. It then checks that the saved address is the unmodified PC, that the saved break bit is 0, and that `take_int` was high. A second overlap is a new non-maskable request that arrives while the maskable latch is already pending. The bench raises both in the same cycle and judges the result by the order of the vectors that are read.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
  parameter int          I_BIT      = 2,
  parameter int          B_BIT      = 4,
  parameter int          U_BIT      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic        boundary,
  input  logic        brk_req,
  input  logic [15:0] pc_in,
  input  logic [7:0]  sp_in,
  input  logic [7:0]  status_in,
  output logic        take_int,
  output logic        busy,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  sp_out,
  output logic [7:0]  status_out
);
  typedef enum logic [2:0] {S_IDLE, S_PCH, S_PCL, S_PSR, S_VLO, S_VHI, S_DONE} state_t;

  state_t      state;
  logic        nmi_q, nmi_pend, irq_pend;
  logic        is_nmi, is_hw;
  logic [15:0] pc_r;
  logic [7:0]  sp_r, st_r, vec_lo;

  logic        pend, nmi_rise, start_sw;
  logic [15:0] ret_pc, vec_base;
  logic [7:0]  psr_push;

  assign pend     = nmi_pend | irq_pend;
  assign busy     = state != S_IDLE;
  assign take_int = boundary & ~busy & pend;
  assign start_sw = boundary & ~busy & brk_req & ~pend;
  assign nmi_rise = nmi_req & ~nmi_q;
  assign ret_pc   = is_hw ? pc_r : pc_r + 16'd2;
  assign vec_base = is_nmi ? NMI_VEC : IRQ_VEC;

  always_comb begin
    psr_push        = st_r;
    psr_push[U_BIT] = 1'b1;
    psr_push[B_BIT] = ~is_hw;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = {STACK_PAGE, sp_r};
    mem_wdata = 8'h00;
    case (state)
      S_PCH: begin mem_we = 1'b1; mem_wdata = ret_pc[15:8]; end
      S_PCL: begin mem_we = 1'b1; mem_wdata = ret_pc[7:0]; end
      S_PSR: begin mem_we = 1'b1; mem_wdata = psr_push; end
      S_VLO: begin mem_re = 1'b1; mem_addr = vec_base; end
      S_VHI: begin mem_re = 1'b1; mem_addr = vec_base + 16'd1; end
      default: ;
    endcase
  end

  assign done   = state == S_DONE;
  assign sp_out = sp_r;

  always_comb begin
    status_out        = st_r;
    status_out[I_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      irq_pend <= 1'b0;
      is_nmi   <= 1'b0;
      is_hw    <= 1'b0;
      pc_r     <= '0;
      sp_r     <= '0;
      st_r     <= '0;
      vec_lo   <= '0;
      pc_out   <= '0;
    end else begin
      nmi_q <= nmi_req;

      if (!busy && irq_req && !status_in[I_BIT])
        irq_pend <= 1'b1;
      else if (state == S_VHI && is_hw && !is_nmi)
        irq_pend <= 1'b0;

      if (nmi_rise)
        nmi_pend <= 1'b1;
      else if (state == S_VHI && is_nmi)
        nmi_pend <= 1'b0;

      case (state)
        S_IDLE: if (take_int || start_sw) begin
          state  <= S_PCH;
          is_hw  <= take_int;
          is_nmi <= take_int & nmi_pend;
          pc_r   <= pc_in;
          sp_r   <= sp_in;
          st_r   <= status_in;
        end
        S_PCH: begin sp_r <= sp_r - 8'd1; state <= S_PCL; end
        S_PCL: begin sp_r <= sp_r - 8'd1; state <= S_PSR; end
        S_PSR: begin sp_r <= sp_r - 8'd1; state <= S_VLO; end
        S_VLO: begin vec_lo <= mem_rdata; state <= S_VHI; end
        S_VHI: begin pc_out <= {mem_rdata, vec_lo}; state <= S_DONE; end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] NMI_VEC    = 16'hFFFA,
  parameter logic [15:0] IRQ_VEC    = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        busy,
  input logic        take_int,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic        done,
  input logic        i_out
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |-> boundary && !busy); // R2
  AST_TAKE_STARTS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> busy && mem_we); // R2
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE); // R4
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R4
  AST_VECTOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr == NMI_VEC || mem_addr == NMI_VEC + 16'd1 ||
                mem_addr == IRQ_VEC || mem_addr == IRQ_VEC + 16'd1)); // R7
  AST_I_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> i_out); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_VECTOR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) |=> done); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .STACK_PAGE(STACK_PAGE), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .busy(busy),
  .take_int(take_int), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .done(done), .i_out(status_out[I_BIT])
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0, irq_req = 1'b0, boundary = 1'b0, brk_req = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  sp = '0, st = '0;
  logic        take_int, busy, mem_we, mem_re, done;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, sp_out, status_out;
  logic [15:0] vnmi = 16'h3000, virq = 16'h2000;

  int nrun = 0, nfail = 0;
  int wcnt = 0;
  logic [15:0] la [0:1023];
  logic [7:0]  ld [0:1023];

  always #5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .boundary(boundary), .brk_req(brk_req), .pc_in(pc), .sp_in(sp),
    .status_in(st), .take_int(take_int), .busy(busy), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .pc_out(pc_out), .sp_out(sp_out),
    .status_out(status_out)
  );

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = vnmi[7:0];
      16'hFFFB: mem_rdata = vnmi[15:8];
      16'hFFFE: mem_rdata = virq[7:0];
      16'hFFFF: mem_rdata = virq[15:8];
      default:  mem_rdata = 8'hEE;
    endcase
  end

  always @(posedge clk) if (mem_we) begin
    la[wcnt % 1024] <= mem_addr;
    ld[wcnt % 1024] <= mem_wdata;
    wcnt <= wcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_push(input logic [7:0] s, input bit hw);
    logic [7:0] r = s;
    r[5] = 1'b1;
    r[4] = ~hw;
    return r;
  endfunction

  task automatic entry(input bit brk, input bit exp_nmi, input bit exp_hw, input bit poke);
    int base, lat;
    logic [15:0] rpc, vec;
    @(negedge clk);
    boundary = 1'b1; brk_req = brk;
    base = wcnt;
    #1 chk(take_int == exp_hw, "R2/R11 take_int", take_int, exp_hw);
    lat = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) begin boundary = 1'b0; brk_req = 1'b0; end
      if (poke && k == 2) begin boundary = 1'b1; brk_req = 1'b1; end
      if (poke && k == 3) begin boundary = 1'b0; brk_req = 1'b0; end
      if (done) begin lat = k; break; end
    end
    chk(lat == 6, "R10 done latency", lat, 6);
    chk(wcnt - base == 3, "R4 write count", wcnt - base, 3);
    rpc = exp_hw ? pc : pc + 16'd2;
    vec = exp_nmi ? vnmi : virq;
    chk(la[base % 1024] == {8'h01, sp} && ld[base % 1024] == rpc[15:8],
        "R3/R4 push PC high", {la[base % 1024], ld[base % 1024]}, {8'h01, sp, rpc[15:8]});
    chk(la[(base+1) % 1024] == {8'h01, sp - 8'd1} && ld[(base+1) % 1024] == rpc[7:0],
        "R3/R4 push PC low", {la[(base+1) % 1024], ld[(base+1) % 1024]}, {8'h01, sp - 8'd1, rpc[7:0]});
    chk(la[(base+2) % 1024] == {8'h01, sp - 8'd2} && ld[(base+2) % 1024] == exp_push(st, exp_hw),
        "R5 push status", {la[(base+2) % 1024], ld[(base+2) % 1024]}, {8'h01, sp - 8'd2, exp_push(st, exp_hw)});
    chk(pc_out == vec, "R7 vector", pc_out, vec);
    chk(sp_out == sp - 8'd3, "R4 sp_out", sp_out, sp - 8'd3);
    chk(status_out == (st | 8'h04), "R6 status_out", status_out, st | 8'h04);
    @(negedge clk);
    chk(!done && !busy, "R10/R11 back to idle", {done, busy}, 0);
  endtask

  task automatic no_entry();
    int w0;
    @(negedge clk);
    boundary = 1'b1;
    w0 = wcnt;
    #1 chk(take_int == 1'b0, "R1/R9/R10 no take", take_int, 0);
    @(negedge clk) boundary = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && wcnt == w0, "R1/R9/R10 stays idle", wcnt - w0, 0);
  endtask

  task automatic latch_irq();
    @(negedge clk) irq_req = 1'b1;
    @(negedge clk) irq_req = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re && !take_int, "R2 reset state",
        {busy, done, mem_we, mem_re, take_int}, 0);
    rst_n = 1'b1;

    // R1/R7 plain IRQ with I clear
    pc = 16'h1234; sp = 8'hFD; st = 8'h20;
    latch_irq();
    entry(0, 0, 1, 0);

    // R1 masked IRQ is lost, even after I clears
    st = 8'h24;
    latch_irq();
    no_entry();
    st = 8'h20;
    no_entry();

    // R1 NMI while I set; R9 held level yields one entry
    st = 8'h2C; pc = 16'hABCD; sp = 8'h80;
    @(negedge clk) nmi_req = 1'b1;
    entry(0, 1, 1, 0);
    no_entry();
    @(negedge clk) nmi_req = 1'b0;
    @(negedge clk) nmi_req = 1'b1;
    entry(0, 1, 1, 0);
    @(negedge clk) nmi_req = 1'b0;

    // R8 both pending: NMI first then IRQ
    st = 8'hC3; pc = 16'h4000; sp = 8'h10;
    @(negedge clk) begin irq_req = 1'b1; nmi_req = 1'b1; end
    @(negedge clk) irq_req = 1'b0;
    entry(0, 1, 1, 0);
    entry(0, 0, 1, 0);
    @(negedge clk) nmi_req = 1'b0;
    no_entry();

    // R3/R5 software break, with boundary poked while busy (R11)
    st = 8'h08; pc = 16'h0200; sp = 8'hFF;
    entry(1, 0, 0, 1);

    // R11 break and pending IRQ at the same boundary
    st = 8'h01; pc = 16'h0300;
    latch_irq();
    entry(1, 0, 1, 0);

    // R4 stack pointer wrap, R3 PC wrap on break
    sp = 8'h01; pc = 16'hFFFF; st = 8'h00;
    entry(1, 0, 0, 0);

    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = $urandom_range(2);
      pc = 16'($urandom); sp = 8'($urandom); st = 8'($urandom);
      vnmi = 16'($urandom); virq = 16'($urandom);
      if (kind == 0) begin
        st[2] = 1'b0;
        latch_irq();
        entry(0, 0, 1, 0);
      end else if (kind == 1) begin
        @(negedge clk) nmi_req = 1'b1;
        entry(0, 1, 1, 0);
        @(negedge clk) nmi_req = 1'b0;
      end else begin
        entry(1, 0, 0, 0);
      end
    end
    report();
  end
endmodule